// File: doc/BRIEF.md
# Bloom Filter Signature Scanner

This block screens a byte stream for fixed 8-byte signatures. Each accepted byte moves an 8-byte sliding window forward, and the block tests the window against a 256-bit Bloom filter. A signature is added by a one-cycle insert strobe. The strobe sets the filter bits that the K hashes of the signature select. After that, any window whose K bits are all set comes out as a candidate. The candidate carries the window value and its byte offset within the packet.

A candidate is only a possible match. A separate exact-compare stage sits downstream and decides whether it is real. Packets are 64 bytes long, and a 256-byte scan batch holds four of them. A start marker or an end marker restarts the window, so no window ever spans two packets. The insert port and the lookup path use the same hash logic. For that reason, an insert takes the cycle and holds the stream off for that cycle.

Back-pressure rules:
- The stream input is valid/ready. A byte moves only on a cycle where both `s_valid` and `s_ready` are high.
- `s_ready` is low in three cases: while a candidate waits unaccepted, while an insert is pending, or while a clear is pending.
- The candidate output is valid/ready. A raised `c_valid` and its data stay fixed until `c_ready` is seen high.

Top module: `bloom_scan`

## Requirements
- R1: After reset:
  - `c_valid` is 0 and `s_ready` is 1.
  - All 256 filter bits are 0.
  - Pulsing `clr` for one cycle also returns every filter bit to 0. While `clr` is high, `s_ready` is 0.
- R2: The block uses K = 4 hashes. Bit j (0..7) of the index of hash k is the XOR of the bits of (window AND M(k,j)). M is computed as follows:
  - Start with x = (8k+j+1) * 0x9E3779B97F4A7C15 (mod 2^64).
  - Set x ^= x>>31.
  - Set x *= 0xBF58476D1CE4E5B9.
  - M = x ^ (x>>29).
- R3: An `ins_valid` cycle with `clr` low sets the K filter bits indexed by the hashes of `ins_sig`. Bits that are already 1 stay 1.
- R4: A window produces a candidate only when all K of its indexed filter bits are 1. A window whose bits are not all set produces nothing.
- R5: The window is the last 8 accepted bytes of the current packet. `c_window[63:56]` is the oldest byte and `c_window[7:0]` the newest. Lookups begin with the 8th byte of a packet.
- R6: `c_offset` is the index within the packet of the window's oldest byte. The first byte of a packet has index 0, so the offset runs from 0 to 56.
- R7: A byte with `s_sop` high is index 0 of a new packet, and the window is emptied before it enters. The byte after an `s_eop` byte is also index 0, even when `s_sop` is low.
- R8: While `ins_valid` is high, `s_ready` is 0, so no byte is taken in that cycle.
- R9: While `c_valid` is high and `c_ready` is low:
  - `c_valid`, `c_window` and `c_offset` hold their values into the next cycle.
  - `s_ready` is 0.
- R10: A byte that completes a hitting window is accepted on a clock edge. The matching candidate is on the outputs immediately after that same edge.
- R11: When `clr` and `ins_valid` are high in the same cycle, the clear wins and the insert sets no bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Clear all filter bits |
| ins_valid | input | 1 | Insert strobe, one signature per cycle |
| ins_sig | input | 64 | Signature to insert |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream byte accepted when high with s_valid |
| s_data | input | 8 | Stream byte |
| s_sop | input | 1 | Byte is the first of a packet |
| s_eop | input | 1 | Byte is the last of a packet |
| c_valid | output | 1 | Candidate available |
| c_ready | input | 1 | Downstream takes the candidate |
| c_window | output | 64 | Window value, oldest byte in the top bits |
| c_offset | output | 6 | Packet index of the window's oldest byte |

## Verification
The bench places inserted signatures at the first window position and the last one (offsets 0 and 56), and at an interior offset. A design that is off by one in its window start would drop the signature at offset 0 or report shifted offsets. The bench also gives a start marker partway through a signature, and a packet that follows an end marker with no start marker. A design that did not flush its window would report windows that join two packets.

Random back-pressure on the candidate port checks for lost or repeated candidates. Clears, including a clear that coincides with an insert, must leave a filter that yields nothing. An insert that overlaps a pending byte must stall the byte and must not corrupt the filter.

// File: rtl/bloom_pkg.sv
package bloom_pkg;
  localparam int WIN_BYTES = 8;
  localparam int WIN_W     = WIN_BYTES * 8;
  localparam int FILT_BITS = 256;
  localparam int IDX_W     = $clog2(FILT_BITS);
  localparam int PKT_BYTES = 64;
  localparam int OFF_W     = $clog2(PKT_BYTES);

  // Fixed per-hash matrix row: one 64-bit mask per index bit.
  function automatic logic [WIN_W-1:0] h3_row(input int k, input int j);
    logic [63:0] x;
    x = 64'(k * IDX_W + j + 1) * 64'h9E3779B97F4A7C15;
    x = x ^ (x >> 31);
    x = x * 64'hBF58476D1CE4E5B9;
    x = x ^ (x >> 29);
    return x[WIN_W-1:0];
  endfunction
endpackage

// File: rtl/bloom_hash.sv
module bloom_hash
  import bloom_pkg::*;
#(
  parameter int K = 4
) (
  input  logic [WIN_W-1:0]         key,
  output logic [K-1:0][IDX_W-1:0]  idx
);
  for (genvar k = 0; k < K; k++) begin : g_hash
    for (genvar j = 0; j < IDX_W; j++) begin : g_bit
      localparam logic [WIN_W-1:0] ROW = h3_row(k, j);
      assign idx[k][j] = ^(key & ROW);
    end
  end
endmodule

// File: rtl/bloom_bits.sv
module bloom_bits
  import bloom_pkg::*;
#(
  parameter int K = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     set_en,
  input  logic [K-1:0][IDX_W-1:0]  idx,
  output logic                     all_set
);
  logic [FILT_BITS-1:0] bits_q;
  logic [K-1:0]         probe;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      bits_q <= '0;
    end else if (set_en) begin
      for (int k = 0; k < K; k++) bits_q[idx[k]] <= 1'b1;
    end
  end

  for (genvar k = 0; k < K; k++) begin : g_probe
    assign probe[k] = bits_q[idx[k]];
  end
  assign all_set = &probe;

  // R1
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (bits_q == '0));

  for (genvar k = 0; k < K; k++) begin : g_chk
    // R3
    set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_en && !clr) |=> bits_q[$past(idx[k])]);
  end
endmodule

// File: rtl/bloom_window.sv
module bloom_window
  import bloom_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [7:0]        data,
  input  logic              sop,
  input  logic              eop,
  output logic [WIN_W-1:0]  win_next,
  output logic              full_next,
  output logic [OFF_W-1:0]  off_next
);
  localparam int CNT_W = OFF_W + 1;

  logic [WIN_W-1:0] win_q;
  logic [CNT_W-1:0] cnt_q;
  logic [OFF_W-1:0] pos;

  assign pos       = sop ? '0 : cnt_q[OFF_W-1:0];
  assign win_next  = sop ? {{(WIN_W-8){1'b0}}, data}
                         : {win_q[WIN_W-9:0], data};
  assign full_next = (pos >= OFF_W'(WIN_BYTES - 1));
  assign off_next  = pos - OFF_W'(WIN_BYTES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q <= '0;
      cnt_q <= '0;
    end else if (take) begin
      win_q <= eop ? '0 : win_next;
      cnt_q <= eop ? '0 : CNT_W'(pos) + CNT_W'(1);
    end
  end

  // R7
  eop_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && eop) |=> (cnt_q == '0));
endmodule

// File: rtl/bloom_scan.sv
module bloom_scan
  import bloom_pkg::*;
#(
  parameter int K = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              ins_valid,
  input  logic [WIN_W-1:0]  ins_sig,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [7:0]        s_data,
  input  logic              s_sop,
  input  logic              s_eop,
  output logic              c_valid,
  input  logic              c_ready,
  output logic [WIN_W-1:0]  c_window,
  output logic [OFF_W-1:0]  c_offset
);
  logic                    take;
  logic [WIN_W-1:0]        win_next;
  logic                    full_next;
  logic [OFF_W-1:0]        off_next;
  logic [WIN_W-1:0]        hkey;
  logic [K-1:0][IDX_W-1:0] idx;
  logic                    hit;

  assign s_ready = !ins_valid && !clr && (!c_valid || c_ready);
  assign take    = s_valid && s_ready;
  assign hkey    = ins_valid ? ins_sig : win_next;

  bloom_window u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .data      (s_data),
    .sop       (s_sop),
    .eop       (s_eop),
    .win_next  (win_next),
    .full_next (full_next),
    .off_next  (off_next)
  );

  bloom_hash #(.K(K)) u_hash (
    .key (hkey),
    .idx (idx)
  );

  bloom_bits #(.K(K)) u_bits (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .set_en  (ins_valid && !clr),
    .idx     (idx),
    .all_set (hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_valid  <= 1'b0;
      c_window <= '0;
      c_offset <= '0;
    end else if (take) begin
      c_valid  <= hit && full_next;
      c_window <= win_next;
      c_offset <= off_next;
    end else if (c_ready) begin
      c_valid  <= 1'b0;
    end
  end

  // R9
  cand_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_valid && !c_ready) |=> (c_valid && $stable(c_window) && $stable(c_offset)));

  // R4
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !hit) |=> !c_valid);

  // R10
  cand_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(c_valid) |-> $past(take));

  // R6
  offset_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_valid |-> (c_offset <= OFF_W'(PKT_BYTES - WIN_BYTES)));
endmodule

// File: tb/sim_bloom_scan.sv
module sim_bloom_scan;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        clr = 0;
  logic        ins_valid = 0;
  logic [63:0] ins_sig = '0;
  logic        s_valid = 0;
  logic        s_ready;
  logic [7:0]  s_data = '0;
  logic        s_sop = 0;
  logic        s_eop = 0;
  logic        c_valid;
  logic        c_ready = 1;
  logic [63:0] c_window;
  logic [5:0]  c_offset;

  int n_cmp = 0;
  int n_bad = 0;
  logic        bp_on = 0;
  logic [15:0] lfsr = 16'hACE1;

  logic [255:0] ref_bits = '0;
  logic [63:0]  ref_win = '0;
  int           ref_cnt = 0;
  logic [69:0]  exp_q[$];

  always #2.5 clk = ~clk;

  bloom_scan u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ins_valid(ins_valid), .ins_sig(ins_sig),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_sop(s_sop), .s_eop(s_eop),
    .c_valid(c_valid), .c_ready(c_ready), .c_window(c_window), .c_offset(c_offset)
  );

  // R2 matrix rows and index, from the requirement text
  function automatic logic [63:0] spec_row(int k, int j);
    logic [63:0] x;
    x = 64'(k * 8 + j + 1) * 64'h9E3779B97F4A7C15;
    x = x ^ (x >> 31);
    x = x * 64'hBF58476D1CE4E5B9;
    return x ^ (x >> 29);
  endfunction

  function automatic logic [7:0] spec_idx(int k, logic [63:0] w);
    logic [7:0] r;
    for (int j = 0; j < 8; j++) r[j] = ^(w & spec_row(k, j));
    return r;
  endfunction

  function automatic logic spec_hit(logic [63:0] w);
    logic h = 1'b1;
    for (int k = 0; k < 4; k++) h &= ref_bits[spec_idx(k, w)];
    return h;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      c_ready = bp_on ? lfsr[0] : 1'b1;
      if (c_valid && c_ready) begin
        if (exp_q.size() == 0) begin
          check(0, "R4 unexpected candidate", c_window, 64'h0);
        end else begin
          logic [69:0] e;
          e = exp_q.pop_front();
          // R5 R6 window and offset
          check({c_offset, c_window} == e, "R5/R6 candidate", {c_offset[3:0], c_window[59:0]},
                {e[67:64], e[59:0]});
        end
      end
    end
  end

  task automatic send_byte(input logic [7:0] b, input bit sop, input bit eop);
    bit ok;
    s_valid = 1; s_data = b; s_sop = sop; s_eop = eop;
    forever begin
      #1;
      ok = s_ready;
      @(posedge clk);
      if (ok) break;
      @(negedge clk);
    end
    if (sop) begin ref_win = {56'b0, b}; ref_cnt = 0; end
    else ref_win = {ref_win[55:0], b};
    if (ref_cnt >= 7 && spec_hit(ref_win))
      exp_q.push_back({6'(ref_cnt - 7), ref_win});
    ref_cnt = eop ? 0 : (ref_cnt + 1) % 64;
    if (eop) ref_win = '0;
    @(negedge clk);
    s_valid = 0; s_sop = 0; s_eop = 0;
  endtask

  task automatic send_packet(input logic [511:0] p);
    for (int i = 0; i < 64; i++) send_byte(p[511 - 8*i -: 8], i == 0, i == 63);
  endtask

  task automatic do_insert(input logic [63:0] sig);
    @(negedge clk);
    ins_valid = 1; ins_sig = sig; s_valid = 1; s_data = 8'h5A;
    #1;
    // R8 insert stalls the stream
    check(s_ready == 0, "R8 stall on insert", s_ready, 0);
    @(posedge clk);
    for (int k = 0; k < 4; k++) ref_bits[spec_idx(k, sig)] = 1'b1;
    @(negedge clk);
    ins_valid = 0; s_valid = 0;
  endtask

  task automatic drain();
    bp_on = 0;
    for (int i = 0; i < 50 && (exp_q.size() != 0 || c_valid); i++) @(negedge clk);
    check(exp_q.size() == 0, "R10 all candidates seen", exp_q.size(), 0);
  endtask

  function automatic logic [511:0] rand_pkt(int seed);
    logic [511:0] p;
    logic [31:0] s = 32'(seed) * 32'h01000193 + 32'h811C9DC5;
    for (int i = 0; i < 16; i++) begin
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      p[32*i +: 32] = s;
    end
    return p;
  endfunction

  initial begin : watchdog
    #(5ns * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  localparam logic [63:0] SIG_A = 64'hDEADBEEF01234567;
  localparam logic [63:0] SIG_B = 64'h0F1E2D3C4B5A6978;
  localparam logic [63:0] SIG_C = 64'h8899AABBCCDDEEFF;

  initial begin
    logic [511:0] p;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(c_valid == 0, "R1 c_valid after reset", c_valid, 0);
    check(s_ready == 1, "R1 s_ready after reset", s_ready, 1);

    // R1 R4 empty filter: no candidates
    send_packet(rand_pkt(1));
    send_packet(rand_pkt(2));
    drain();

    do_insert(SIG_A);
    do_insert(SIG_B);
    do_insert(SIG_C);
    do_insert(SIG_A); // R3 idempotent re-insert

    // R5 R6 signatures at offsets 0, 20, 56
    p = rand_pkt(3);
    p[511 -: 64] = SIG_A;
    p[511 - 160 -: 64] = SIG_B;
    p[63:0] = SIG_C;
    send_packet(p);
    drain();

    // R10 one-cycle latency
    send_byte(8'h11, 1, 0);
    for (int i = 0; i < 8; i++) send_byte(SIG_B[63 - 8*i -: 8], 0, i == 7);
    check(c_valid == 1 && c_window == SIG_B, "R10 candidate after edge", c_window, SIG_B);
    check(c_offset == 6'd1, "R6 offset 1", c_offset, 1);
    drain();

    // R9 back-pressure
    bp_on = 1;
    for (int r = 0; r < 3; r++) begin
      p = rand_pkt(10 + r);
      p[511 - 8*(5 + 17*r) -: 64] = SIG_A;
      p[511 - 8*(30 + r) -: 64] = SIG_C;
      send_packet(p);
    end
    drain();

    // R7 sop mid-signature flushes the window
    for (int i = 0; i < 5; i++) send_byte(SIG_A[63 - 8*i -: 8], i == 0, 0);
    for (int i = 0; i < 8; i++) send_byte(SIG_A[63 - 8*i -: 8], i == 0, 0);
    send_byte(8'h00, 0, 1);
    // R7 packet after eop without sop starts at index 0
    for (int i = 0; i < 8; i++) send_byte(SIG_C[63 - 8*i -: 8], 0, i == 7);
    drain();

    // R1 clear empties the filter
    @(negedge clk);
    clr = 1; s_valid = 1;
    #1;
    check(s_ready == 0, "R1 stall on clear", s_ready, 0);
    @(posedge clk);
    ref_bits = '0;
    @(negedge clk);
    clr = 0; s_valid = 0;
    p = rand_pkt(20); p[511 -: 64] = SIG_A;
    send_packet(p);
    drain();

    // R11 clear with insert: clear wins
    @(negedge clk);
    clr = 1; ins_valid = 1; ins_sig = SIG_B;
    @(posedge clk);
    @(negedge clk);
    clr = 0; ins_valid = 0;
    p = rand_pkt(21); p[511 - 80 -: 64] = SIG_B;
    send_packet(p);
    drain();
    check(c_valid == 0, "R11 no candidate after clear+insert", c_valid, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule